// File: doc/BRIEF.md
# I2C Temperature Sensor Poll Sequencer

This block reads a two-byte temperature value from an I2C digital temperature sensor each time a poll tick arrives. It does not generate SCL or SDA itself; it sends a series of byte-level commands to an external byte engine. The commands are start, repeated start, write byte, read byte and stop. For each command the sequencer waits until the engine reports that the command has finished.

One poll is a single combined transaction. The sequencer sends a start and then the target address with the write bit clear. It writes a register pointer byte that selects the temperature register. It then issues a repeated start and sends the address with the read bit set. Two bytes are read: the first is acknowledged and the second is not. A stop ends the transaction.

The two bytes form a 16-bit word, most significant byte first. The word is decoded into whole degrees and a fraction in hundredths, for use by display logic. A valid flag shows that the held word comes from a complete, acknowledged transaction. The poll period is set by the tick input, so the caller chooses it; the intended rate is once per second.

Top module: `tsensePoller`

## Requirements
- R1: After reset, `tempValid` is 0, `rawWord` is 0 and `engValid` is 0.
- R2: A `pollTick` pulse while idle clears `tempValid` on the next clock edge and starts a transaction. A pending command (`engValid` = 1) keeps `engCmd` and `engTx` stable until `engDone`.
- R3: The first three commands are: start (`engCmd` = 0), write of 0x92 (address 0x49 with write bit 0), then write of pointer byte 0x00. Command codes are: 0 start, 1 repeated start, 2 write, 3 read, 4 stop.
- R4: After the pointer byte is acknowledged, the sequencer issues a repeated start (code 1) and no stop, then writes 0x93 (address with read bit 1).
- R5: Two reads follow. The first has `engAckOut` = 1 and its byte becomes `rawWord[15:8]`. The second has `engAckOut` = 0 and its byte becomes `rawWord[7:0]`.
- R6: A stop (code 4) follows the second read. `tempValid` stays 0 until that stop finishes, then becomes 1.
- R7: `degInt` equals `rawWord >> 7` (9 bits).
- R8: `degFrac` equals 25 × `rawWord[6:5]`, which gives 0, 25, 50 or 75.
- R9: If `engAckIn` = 0 after any write byte, the next command is a stop. `tempValid` stays 0, `rawWord` keeps its old value, and the block waits for the next tick.
- R10: A `pollTick` that arrives during a transaction has no effect. No extra commands are issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pollTick | input | 1 | One-cycle request to start a poll |
| engValid | output | 1 | A command is pending for the byte engine |
| engCmd | output | 3 | Command code |
| engTx | output | 8 | Byte to transmit for write commands |
| engAckOut | output | 1 | For reads: 1 means acknowledge the received byte |
| engDone | input | 1 | One-cycle pulse: the pending command has finished |
| engRx | input | 8 | Byte received by a read, valid with `engDone` |
| engAckIn | input | 1 | For writes: the target acknowledged, valid with `engDone` |
| rawWord | output | 16 | Last complete temperature word |
| degInt | output | 9 | Whole degrees |
| degFrac | output | 7 | Fraction in hundredths |
| tempValid | output | 1 | The word comes from a complete poll |

## Verification
A wrong controller state appears at the engine port first, on the next command the sequencer issues. Examples are a wrong command code, a wrong address or pointer byte, a wrong acknowledge polarity, or a stop in place of a repeated start. The scoreboard compares every accepted command against the expected order, so such an error is reported within one engine operation. Datapath faults show up on `rawWord` and the decoded fields once `tempValid` rises, which is a few cycles after the stop finishes. NACK cases check that `tempValid` stays low and that the held word is not overwritten.

// File: rtl/tsense_pkg.sv
package tsense_pkg;
  typedef enum logic [2:0] {
    OP_START  = 3'd0,
    OP_RSTART = 3'd1,
    OP_WRITE  = 3'd2,
    OP_READ   = 3'd3,
    OP_STOP   = 3'd4
  } engOp_e;

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_ADDRW, S_PTR, S_RSTART, S_ADDRR, S_RDHI, S_RDLO, S_STOP
  } seqState_e;

  typedef struct packed {
    logic clrValid;
    logic latchHi;
    logic latchLo;
    logic setValid;
  } dpStrobe_t;
endpackage

// File: rtl/tsense_ctrl.sv
module tsense_ctrl
  import tsense_pkg::*;
#(
  parameter logic [6:0] TGT_ADDR = 7'h49,
  parameter logic [7:0] PTR_BYTE = 8'h00
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pollTick,
  input  logic       engDone,
  input  logic       engAckIn,
  output logic       engValid,
  output logic [2:0] engCmd,
  output logic [7:0] engTx,
  output logic       engAckOut,
  output dpStrobe_t  strobe
);
  localparam logic [7:0] ADDR_WR = {TGT_ADDR, 1'b0};
  localparam logic [7:0] ADDR_RD = {TGT_ADDR, 1'b1};

  seqState_e state, stateNext;
  logic      failed, failedNext;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      failed <= 1'b0;
    end else begin
      state  <= stateNext;
      failed <= failedNext;
    end
  end

  always_comb begin
    engValid  = (state != S_IDLE);
    engTx     = 8'h00;
    engAckOut = 1'b0;
    engCmd    = OP_START;
    unique case (state)
      S_START:  engCmd = OP_START;
      S_ADDRW:  begin engCmd = OP_WRITE; engTx = ADDR_WR; end
      S_PTR:    begin engCmd = OP_WRITE; engTx = PTR_BYTE; end
      S_RSTART: engCmd = OP_RSTART;
      S_ADDRR:  begin engCmd = OP_WRITE; engTx = ADDR_RD; end
      S_RDHI:   begin engCmd = OP_READ; engAckOut = 1'b1; end
      S_RDLO:   engCmd = OP_READ;
      S_STOP:   engCmd = OP_STOP;
      default:  engCmd = OP_START;
    endcase
  end

  always_comb begin
    stateNext  = state;
    failedNext = failed;
    strobe     = '0;
    unique case (state)
      S_IDLE: if (pollTick) begin
        stateNext       = S_START;
        failedNext      = 1'b0;
        strobe.clrValid = 1'b1;
      end
      S_START:  if (engDone) stateNext = S_ADDRW;
      S_ADDRW:  if (engDone) begin
        stateNext  = engAckIn ? S_PTR : S_STOP;
        failedNext = !engAckIn;
      end
      S_PTR:    if (engDone) begin
        stateNext  = engAckIn ? S_RSTART : S_STOP;
        failedNext = !engAckIn;
      end
      S_RSTART: if (engDone) stateNext = S_ADDRR;
      S_ADDRR:  if (engDone) begin
        stateNext  = engAckIn ? S_RDHI : S_STOP;
        failedNext = !engAckIn;
      end
      S_RDHI:   if (engDone) begin
        stateNext      = S_RDLO;
        strobe.latchHi = 1'b1;
      end
      S_RDLO:   if (engDone) begin
        stateNext      = S_STOP;
        strobe.latchLo = 1'b1;
      end
      S_STOP:   if (engDone) begin
        stateNext       = S_IDLE;
        strobe.setValid = !failed;
      end
      default:  stateNext = S_IDLE;
    endcase
  end

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (engValid && !engDone) |=> (engValid && $stable(engCmd) && $stable(engTx))); // R2

  AST_NACK_STOP: assert property (@(posedge clk) disable iff (rst)
    (engValid && engDone && !engAckIn && engCmd == OP_WRITE) |=> (engValid && engCmd == OP_STOP)); // R9

  AST_RSTART_AFTER_PTR: assert property (@(posedge clk) disable iff (rst)
    (engValid && engDone && engAckIn && engCmd == OP_WRITE && engTx == PTR_BYTE && state == S_PTR)
      |=> (engCmd == OP_RSTART)); // R4
endmodule

// File: rtl/tsense_dp.sv
module tsense_dp
  import tsense_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  dpStrobe_t           strobe,
  input  logic [BYTE_W-1:0]   engRx,
  output logic [2*BYTE_W-1:0] rawWord,
  output logic [2*BYTE_W-8:0] degInt,
  output logic [6:0]          degFrac,
  output logic                tempValid
);
  localparam int WORD_W = 2 * BYTE_W;
  localparam int INT_SH = 7;

  logic [BYTE_W-1:0] hiHold;

  always_ff @(posedge clk) begin
    if (rst) begin
      hiHold    <= '0;
      rawWord   <= '0;
      tempValid <= 1'b0;
    end else begin
      if (strobe.latchHi) hiHold <= engRx;
      if (strobe.latchLo) rawWord <= {hiHold, engRx};
      if (strobe.clrValid) tempValid <= 1'b0;
      else if (strobe.setValid) tempValid <= 1'b1;
    end
  end

  always_comb begin
    degInt  = rawWord[WORD_W-1:INT_SH];
    degFrac = 7'(rawWord[6:5]) * 7'd25;
  end

  AST_VALID_CLR: assert property (@(posedge clk) disable iff (rst)
    strobe.clrValid |=> !tempValid); // R2

  AST_WORD_HELD: assert property (@(posedge clk) disable iff (rst)
    (tempValid && $past(tempValid)) |-> $stable(rawWord)); // R6

  AST_FRAC_RANGE: assert property (@(posedge clk) disable iff (rst)
    (degFrac <= 7'd75) && (degFrac % 7'd25 == 7'd0)); // R8
endmodule

// File: rtl/tsensePoller.sv
module tsensePoller
  import tsense_pkg::*;
#(
  parameter logic [6:0] TGT_ADDR = 7'h49,
  parameter logic [7:0] PTR_BYTE = 8'h00
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        pollTick,
  output logic        engValid,
  output logic [2:0]  engCmd,
  output logic [7:0]  engTx,
  output logic        engAckOut,
  input  logic        engDone,
  input  logic [7:0]  engRx,
  input  logic        engAckIn,
  output logic [15:0] rawWord,
  output logic [8:0]  degInt,
  output logic [6:0]  degFrac,
  output logic        tempValid
);
  dpStrobe_t strobe;

  tsense_ctrl #(.TGT_ADDR(TGT_ADDR), .PTR_BYTE(PTR_BYTE)) uCtrl (
    .clk(clk), .rst(rst), .pollTick(pollTick), .engDone(engDone),
    .engAckIn(engAckIn), .engValid(engValid), .engCmd(engCmd),
    .engTx(engTx), .engAckOut(engAckOut), .strobe(strobe)
  );

  tsense_dp #(.BYTE_W(8)) uDp (
    .clk(clk), .rst(rst), .strobe(strobe), .engRx(engRx),
    .rawWord(rawWord), .degInt(degInt), .degFrac(degFrac),
    .tempValid(tempValid)
  );
endmodule

// File: tb/tb_tsensePoller.sv
module tb_tsensePoller;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pollTick = 1'b0;
  logic        engValid, engAckOut, tempValid;
  logic [2:0]  engCmd;
  logic [7:0]  engTx;
  logic        engDone = 1'b0;
  logic [7:0]  engRx = 8'h00;
  logic        engAckIn = 1'b0;
  logic [15:0] rawWord;
  logic [8:0]  degInt;
  logic [6:0]  degFrac;

  always #4 clk = ~clk;

  tsensePoller dut (
    .clk(clk), .rst(rst), .pollTick(pollTick), .engValid(engValid),
    .engCmd(engCmd), .engTx(engTx), .engAckOut(engAckOut),
    .engDone(engDone), .engRx(engRx), .engAckIn(engAckIn),
    .rawWord(rawWord), .degInt(degInt), .degFrac(degFrac),
    .tempValid(tempValid)
  );

  int nCmp = 0;
  int nBad = 0;
  logic [11:0] expQ[$];
  logic [7:0] rxHi, rxLo;
  int nackAt = 0;
  int wrIdx = 0;
  int rdIdx = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] mk(input logic [2:0] op, input logic [7:0] tx, input logic ack);
    return {op, tx, ack};
  endfunction

  // Engine model and monitor: compares each accepted command with the scoreboard
  logic busy = 1'b0;
  int   cnt = 0;
  logic [2:0] curOp;
  always @(negedge clk) begin
    if (engDone) engDone <= 1'b0;
    if (busy) begin
      if (cnt == 0) begin
        busy <= 1'b0;
        engDone <= 1'b1;
        if (curOp == 3'd2) begin
          wrIdx++;
          engAckIn <= (wrIdx != nackAt);
        end else if (curOp == 3'd3) begin
          engRx <= (rdIdx == 0) ? rxHi : rxLo;
          rdIdx++;
        end
      end else cnt--;
    end else if (engValid && !engDone && !rst) begin
      logic [11:0] e;
      busy <= 1'b1;
      cnt  <= 2;
      curOp = engCmd;
      if (expQ.size() == 0) begin
        check(1'b0, "R10 unexpected command", engCmd, 0);
      end else begin
        e = expQ.pop_front();
        check(engCmd == e[11:9], "R3/R4/R5/R6/R9 command code", engCmd, e[11:9]);
        if (e[11:9] == 3'd2) check(engTx == e[8:1], "R3/R4 write byte", engTx, e[8:1]);
        if (e[11:9] == 3'd3) check(engAckOut == e[0], "R5 read ack", engAckOut, e[0]);
      end
    end
  end

  task automatic tick();
    @(negedge clk) pollTick = 1'b1;
    @(negedge clk) pollTick = 1'b0;
  endtask

  // Driver: pushes the expected command order, then starts a poll
  task automatic poll(input logic [7:0] hi, input logic [7:0] lo, input int nack, input bit extraTick);
    rxHi = hi; rxLo = lo; nackAt = nack; wrIdx = 0; rdIdx = 0;
    expQ.push_back(mk(3'd0, 8'h00, 1'b0));
    expQ.push_back(mk(3'd2, 8'h92, 1'b0));
    if (nack != 1) begin
      expQ.push_back(mk(3'd2, 8'h00, 1'b0));
      if (nack != 2) begin
        expQ.push_back(mk(3'd1, 8'h00, 1'b0));
        expQ.push_back(mk(3'd2, 8'h93, 1'b0));
        if (nack != 3) begin
          expQ.push_back(mk(3'd3, 8'h00, 1'b1));
          expQ.push_back(mk(3'd3, 8'h00, 1'b0));
        end
      end
    end
    expQ.push_back(mk(3'd4, 8'h00, 1'b0));
    tick();
    check(tempValid == 1'b0, "R2 valid cleared at poll", tempValid, 0);
    repeat (20) @(negedge clk);
    check(tempValid == 1'b0, "R6 valid low mid-transaction", tempValid, 0);
    if (extraTick) tick();
    repeat (100) @(negedge clk);
    check(expQ.size() == 0, "R3/R6 all commands issued", expQ.size(), 0);
    check(engValid == 1'b0, "R9/R10 idle after poll", engValid, 0);
  endtask

  task automatic expectGood(input logic [15:0] w);
    check(tempValid == 1'b1, "R6 valid after stop", tempValid, 1);
    check(rawWord == w, "R5 raw word", rawWord, w);
    check(degInt == 9'(w >> 7), "R7 integer degrees", degInt, w >> 7);
    check(degFrac == 7'(25 * w[6:5]), "R8 fraction", degFrac, 25 * w[6:5]);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nBad++; nCmp++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(tempValid == 1'b0, "R1 reset valid", tempValid, 0);
    check(rawWord == 16'h0, "R1 reset word", rawWord, 0);
    check(engValid == 1'b0, "R1 reset idle", engValid, 0);

    poll(8'h0C, 8'hE0, 0, 1'b0); expectGood(16'h0CE0);
    poll(8'h1A, 8'h40, 0, 1'b0); expectGood(16'h1A40);
    poll(8'hFF, 8'hA0, 0, 1'b1); expectGood(16'hFFA0); // R10 extra tick ignored
    poll(8'h12, 8'h34, 0, 1'b0); expectGood(16'h1234);

    poll(8'h55, 8'h55, 1, 1'b0); // R9 address NACK
    check(tempValid == 1'b0, "R9 valid low after address nack", tempValid, 0);
    check(rawWord == 16'h1234, "R9 word kept", rawWord, 16'h1234);
    poll(8'h55, 8'h55, 2, 1'b0); // R9 pointer NACK
    check(tempValid == 1'b0, "R9 valid low after pointer nack", tempValid, 0);
    poll(8'h55, 8'h55, 3, 1'b0); // R9 read-address NACK
    check(rawWord == 16'h1234, "R9 word kept after read-address nack", rawWord, 16'h1234);

    poll(8'h00, 8'h20, 0, 1'b0); expectGood(16'h0020);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule